// File: doc/BRIEF.md
# Upstream Burst Transmitter Controller

Each slave node on a shared point-to-multipoint optical tree runs one copy of this controller. It watches the decoded downstream byte stream, which carries one byte per clock with a control-character flag. A comma character marks the start of each downstream superframe. A fixed number of bytes later comes the grant byte, which names the one node allowed to use the shared upstream channel next. Every node receives the grant. Only the node whose static address matches it starts a burst.

A burst is a fixed sequence. The laser is switched on and held for a settling time. Then come a run of alternating-bit training bytes for the burst-mode receiver at the head end, a comma, the node's own address, and a payload window of fixed length. The window is filled from a show-ahead payload FIFO, with fill bytes sent whenever the FIFO is empty. The laser then goes dark for a guard interval before the node can accept another grant. That guard is this node's share of the silent gap between bursts from different nodes. All lengths are parameters counted in byte clocks.

Top module: `upburst_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, laser_en is 0, up_byte is 0x00, up_is_k is 0 and fifo_rd is 0.
- R2: A comma is a byte 0xBC with dn_is_k=1. The byte at position GRANT_POS (default 259, counting the byte right after the comma as 1) is a grant for this node when dn_is_k=0 and the byte equals node_addr zero-extended to 8 bits. laser_en rises in the clock cycle after that byte is presented.
- R3: No burst starts for any of these: a grant-position byte that does not match, a byte carrying the node's address at any other position, a grant-position byte with dn_is_k=1, or any byte while no comma has been seen since reset or since the last grant position.
- R4: For the first SETTLE_LEN cycles of a burst, laser_en is 1 and the node sends 0x00 with up_is_k=0.
- R5: Next come TRAIN_LEN bytes of 0x55 with up_is_k=0, then one byte 0xBC with up_is_k=1, then one byte holding node_addr zero-extended, with up_is_k=0.
- R6: Next comes a payload window of exactly WINDOW_LEN cycles. In each window cycle where fifo_empty=0, up_byte equals fifo_data and fifo_rd is 1. The payload bytes leave in FIFO order.
- R7: In a window cycle where fifo_empty=1, the node sends 0x00 with up_is_k=0 and fifo_rd is 0.
- R8: After the window, laser_en is 0 for GUARD_LEN cycles before the node accepts any grant. A grant that arrives at any time between burst start and the end of the guard is ignored.
- R9: Whenever laser_en is 0, up_byte is 0x00, up_is_k is 0 and fifo_rd is 0.
- R10: A comma restarts the position count, even when it arrives before the previous grant position was reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| dn_byte | input | 8 | Decoded downstream byte |
| dn_is_k | input | 1 | Downstream byte is a control character |
| node_addr | input | ADDR_W | Static address of this node |
| fifo_empty | input | 1 | Payload FIFO has no byte |
| fifo_data | input | 8 | Head byte of payload FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop the payload FIFO head |
| up_byte | output | 8 | Upstream byte to the encoder |
| up_is_k | output | 1 | Upstream byte is a control character |
| laser_en | output | 1 | Upstream laser enable |

## Verification
The hardest case to reach is a second matching grant while a burst is still running. At the default lengths, the payload window is longer than one superframe, so the stimulus keeps the downstream stream running naturally through each burst. It sends a fresh comma right after the first grant and a second matching grant 259 bytes later, which falls inside the payload window. The bench then checks that the window and guard run to completion and that no second burst follows. A realignment case places a comma partway through a superframe. If the design failed to restart its count there, it would miss the real grant.

// File: rtl/upburst_pkg.sv
package upburst_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] COMMA_CODE = 8'hBC;
    localparam logic [BYTE_W-1:0] TRAIN_CODE = 8'h55;
    localparam logic [BYTE_W-1:0] FILL_CODE  = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_TRAIN,
        PH_MARK,
        PH_ID,
        PH_WINDOW,
        PH_GUARD
    } phase_e;

    typedef struct packed {
        logic              is_k;
        logic [BYTE_W-1:0] data;
    } up_sym_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/upburst_grant_det.sv
module upburst_grant_det
    import upburst_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int GRANT_POS = 259
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] dn_byte,
    input  logic              dn_is_k,
    input  logic [ADDR_W-1:0] node_addr,
    output logic              grant_hit
);
    localparam int POS_W = $clog2(GRANT_POS + 1);

    logic              locked;
    logic [POS_W-1:0]  pos;
    logic              is_comma;
    logic [BYTE_W-1:0] own_code;

    assign is_comma = dn_is_k && (dn_byte == COMMA_CODE);
    assign own_code = {{(BYTE_W-ADDR_W){1'b0}}, node_addr};

    // pos holds the position of the byte currently on dn_byte
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            pos    <= '0;
        end else if (is_comma) begin
            locked <= 1'b1;
            pos    <= POS_W'(1);
        end else if (locked) begin
            if (pos == POS_W'(GRANT_POS)) begin
                locked <= 1'b0;
            end
            pos <= pos + POS_W'(1);
        end
    end

    assign grant_hit = locked && !dn_is_k &&
                       (pos == POS_W'(GRANT_POS)) &&
                       (dn_byte == own_code);

endmodule

// File: rtl/upburst_seq.sv
module upburst_seq
    import upburst_pkg::*;
#(
    parameter int SETTLE_LEN = 8,
    parameter int TRAIN_LEN  = 16,
    parameter int WINDOW_LEN = 300,
    parameter int GUARD_LEN  = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   grant_hit,
    output phase_e phase
);
    localparam int MAX_LEN = max_of4(SETTLE_LEN, TRAIN_LEN, WINDOW_LEN, GUARD_LEN);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    phase_e           nxt;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load;

    always_comb begin
        case (phase)
            PH_IDLE:   nxt = PH_SETTLE;
            PH_SETTLE: nxt = PH_TRAIN;
            PH_TRAIN:  nxt = PH_MARK;
            PH_MARK:   nxt = PH_ID;
            PH_ID:     nxt = PH_WINDOW;
            PH_WINDOW: nxt = PH_GUARD;
            default:   nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        case (nxt)
            PH_SETTLE: load = CNT_W'(SETTLE_LEN - 1);
            PH_TRAIN:  load = CNT_W'(TRAIN_LEN - 1);
            PH_WINDOW: load = CNT_W'(WINDOW_LEN - 1);
            PH_GUARD:  load = CNT_W'(GUARD_LEN - 1);
            default:   load = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            remain <= '0;
        end else if (phase == PH_IDLE) begin
            if (grant_hit) begin
                phase  <= nxt;
                remain <= load;
            end
        end else if (remain == '0) begin
            phase  <= nxt;
            remain <= load;
        end else begin
            remain <= remain - CNT_W'(1);
        end
    end

endmodule

// File: rtl/upburst_txmux.sv
module upburst_txmux
    import upburst_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] node_addr,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    output up_sym_t           sym,
    output logic              laser_en,
    output logic              fifo_rd
);
    always_comb begin
        sym      = '{is_k: 1'b0, data: FILL_CODE};
        laser_en = 1'b1;
        fifo_rd  = 1'b0;
        case (phase)
            PH_SETTLE: ;
            PH_TRAIN:  sym.data = TRAIN_CODE;
            PH_MARK:   sym = '{is_k: 1'b1, data: COMMA_CODE};
            PH_ID:     sym.data = {{(BYTE_W-ADDR_W){1'b0}}, node_addr};
            PH_WINDOW: begin
                if (!fifo_empty) begin
                    sym.data = fifo_data;
                    fifo_rd  = 1'b1;
                end
            end
            default:   laser_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/upburst_ctrl.sv
module upburst_ctrl
    import upburst_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int GRANT_POS  = 259,
    parameter int SETTLE_LEN = 8,
    parameter int TRAIN_LEN  = 16,
    parameter int WINDOW_LEN = 300,
    parameter int GUARD_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        dn_byte,
    input  logic              dn_is_k,
    input  logic [ADDR_W-1:0] node_addr,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_data,
    output logic              fifo_rd,
    output logic [7:0]        up_byte,
    output logic              up_is_k,
    output logic              laser_en
);
    logic    grant_hit;
    phase_e  phase;
    up_sym_t sym;

    upburst_grant_det #(
        .ADDR_W    (ADDR_W),
        .GRANT_POS (GRANT_POS)
    ) u_det (
        .clk       (clk),
        .rst       (rst),
        .dn_byte   (dn_byte),
        .dn_is_k   (dn_is_k),
        .node_addr (node_addr),
        .grant_hit (grant_hit)
    );

    upburst_seq #(
        .SETTLE_LEN (SETTLE_LEN),
        .TRAIN_LEN  (TRAIN_LEN),
        .WINDOW_LEN (WINDOW_LEN),
        .GUARD_LEN  (GUARD_LEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .grant_hit (grant_hit),
        .phase     (phase)
    );

    upburst_txmux #(
        .ADDR_W (ADDR_W)
    ) u_mux (
        .phase      (phase),
        .node_addr  (node_addr),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .sym        (sym),
        .laser_en   (laser_en),
        .fifo_rd    (fifo_rd)
    );

    assign up_byte = sym.data;
    assign up_is_k = sym.is_k;

endmodule

// File: rtl/upburst_chk.sv
module upburst_chk #(
    parameter int ADDR_W    = 6,
    parameter int GUARD_LEN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              laser_en,
    input logic [7:0]        up_byte,
    input logic              up_is_k,
    input logic              fifo_rd,
    input logic              fifo_empty,
    input logic [7:0]        fifo_data,
    input logic [ADDR_W-1:0] node_addr,
    input logic              grant_hit
);
    localparam int GAP_W = $clog2(GUARD_LEN + 1);

    // dark cycles since the laser last went off, saturating at GUARD_LEN
    logic [GAP_W-1:0] dark_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dark_cnt <= GAP_W'(GUARD_LEN);
        end else if (laser_en) begin
            dark_cnt <= '0;
        end else if (dark_cnt != GAP_W'(GUARD_LEN)) begin
            dark_cnt <= dark_cnt + GAP_W'(1);
        end
    end

    p_rise_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(laser_en) |-> $past(grant_hit));

    p_dark_line_r9: assert property (@(posedge clk) disable iff (rst)
        !laser_en |-> (up_byte == 8'h00 && !up_is_k && !fifo_rd));

    p_read_in_window_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (laser_en && !fifo_empty && !up_is_k && up_byte == fifo_data));

    p_comma_after_train_r5: assert property (@(posedge clk) disable iff (rst)
        up_is_k |-> (up_byte == 8'hBC && laser_en && $past(up_byte) == 8'h55));

    p_id_after_comma_r5: assert property (@(posedge clk) disable iff (rst)
        $past(up_is_k) |-> (up_byte == {{(8-ADDR_W){1'b0}}, node_addr} && !up_is_k));

    p_guard_gap_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(laser_en) |-> (dark_cnt == GAP_W'(GUARD_LEN)));

endmodule

bind upburst_ctrl upburst_chk #(
    .ADDR_W    (ADDR_W),
    .GUARD_LEN (GUARD_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .laser_en   (laser_en),
    .up_byte    (up_byte),
    .up_is_k    (up_is_k),
    .fifo_rd    (fifo_rd),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .node_addr  (node_addr),
    .grant_hit  (grant_hit)
);

// File: tb/upburst_ctrl_tb.sv
module upburst_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int GPOS   = 259;
    localparam int SET_L  = 8;
    localparam int TRN_L  = 16;
    localparam int WIN_L  = 300;
    localparam int GRD_L  = 4;
    localparam logic [7:0] OWN = 8'h05;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] dn_byte;
    logic       dn_is_k;
    logic [ADDR_W-1:0] node_addr;
    logic       fifo_empty, fifo_rd, up_is_k, laser_en;
    logic [7:0] fifo_data, up_byte;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [7:0] fmem [0:511];
    int wr_ptr = 0;
    int rd_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_data  = fmem[rd_ptr[8:0]];

    always @(posedge clk) begin
        if (fifo_rd && !fifo_empty) rd_ptr <= rd_ptr + 1;
    end

    upburst_ctrl #(
        .ADDR_W(ADDR_W), .GRANT_POS(GPOS), .SETTLE_LEN(SET_L),
        .TRAIN_LEN(TRN_L), .WINDOW_LEN(WIN_L), .GUARD_LEN(GRD_L)
    ) u_dut (
        .clk(clk), .rst(rst), .dn_byte(dn_byte), .dn_is_k(dn_is_k),
        .node_addr(node_addr), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .up_byte(up_byte), .up_is_k(up_is_k), .laser_en(laser_en)
    );

    function automatic logic [7:0] pay(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic step_byte(input logic [7:0] b, input logic k);
        dn_byte = b;
        dn_is_k = k;
        @(negedge clk);
    endtask

    task automatic load_fifo(input int n);
        for (int i = 0; i < n; i++) begin
            fmem[wr_ptr[8:0]] = pay(wr_ptr);
            wr_ptr = wr_ptr + 1;
        end
    endtask

    // comma then n filler bytes; laser must stay dark throughout (R3, R9)
    task automatic lead(input int n, input logic [7:0] fill, input string req);
        int bad = 0;
        step_byte(8'hBC, 1'b1);
        for (int i = 0; i < n; i++) begin
            if (laser_en !== 1'b0 || up_byte !== 8'h00 || up_is_k !== 1'b0) bad++;
            step_byte(fill, 1'b0);
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: lead dark cycles bad=%0d expected 0", req, bad);
        end
    endtask

    task automatic quiet(input int n, input logic [7:0] fill, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (laser_en !== 1'b0 || up_byte !== 8'h00 || up_is_k !== 1'b0 ||
                fifo_rd !== 1'b0) bad++;
            step_byte(fill, 1'b0);
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: quiet cycles with activity=%0d expected 0", req, bad);
        end
    endtask

    // Called right after the grant byte was stepped. Keeps the superframe
    // running: comma at s=1, a second matching grant at s=1+GPOS (R8).
    task automatic burst_check(input int first_idx, input int n_avail);
        int taken = 0;
        int t_end = SET_L + TRN_L + 2 + WIN_L + GRD_L + 12;
        for (int s = 1; s <= t_end; s++) begin
            logic e_las, e_k, e_rd;
            logic [7:0] e_b;
            string req;
            e_las = 1'b1; e_k = 1'b0; e_rd = 1'b0; e_b = 8'h00;
            if (s <= SET_L) req = "R4";
            else if (s <= SET_L + TRN_L) begin req = "R5"; e_b = 8'h55; end
            else if (s == SET_L + TRN_L + 1) begin req = "R5"; e_b = 8'hBC; e_k = 1'b1; end
            else if (s == SET_L + TRN_L + 2) begin req = "R5"; e_b = OWN; end
            else if (s <= SET_L + TRN_L + 2 + WIN_L) begin
                if (taken < n_avail) begin
                    req = "R6"; e_b = pay(first_idx + taken); e_rd = 1'b1;
                end else req = "R7";
            end else begin
                req = "R8"; e_las = 1'b0;
            end
            checks++;
            if (laser_en !== e_las || up_byte !== e_b || up_is_k !== e_k || fifo_rd !== e_rd) begin
                errors++;
                $display("FAIL %s: step %0d got las=%b byte=%h k=%b rd=%b expected las=%b byte=%h k=%b rd=%b",
                         req, s, laser_en, up_byte, up_is_k, fifo_rd, e_las, e_b, e_k, e_rd);
            end
            if (e_rd) taken++;
            if (s == 1) step_byte(8'hBC, 1'b1);
            else if (s == 1 + GPOS) step_byte(OWN, 1'b0);
            else step_byte(8'h00, 1'b0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; dn_byte = 8'h00; dn_is_k = 1'b0; node_addr = OWN[ADDR_W-1:0];
        repeat (3) @(negedge clk);
        checks++;
        if (laser_en !== 1'b0 || up_byte !== 8'h00 || up_is_k !== 1'b0 || fifo_rd !== 1'b0) begin
            errors++;
            $display("FAIL R1: in reset las=%b byte=%h k=%b rd=%b expected 0 00 0 0",
                     laser_en, up_byte, up_is_k, fifo_rd);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (laser_en !== 1'b0 || up_byte !== 8'h00 || up_is_k !== 1'b0 || fifo_rd !== 1'b0) begin
            errors++;
            $display("FAIL R1: after reset las=%b byte=%h k=%b rd=%b expected 0 00 0 0",
                     laser_en, up_byte, up_is_k, fifo_rd);
        end
    endtask

    // R2, R4, R5, R6, R8: full window
    task automatic t_full_burst();
        int first = wr_ptr;
        load_fifo(WIN_L);
        lead(GPOS - 1, OWN, "R3");
        step_byte(OWN, 1'b0);
        checks++;
        if (laser_en !== 1'b1) begin
            errors++;
            $display("FAIL R2: laser_en=%b one cycle after grant expected 1", laser_en);
        end
        burst_check(first, WIN_L);
    endtask

    // R7: FIFO runs dry mid-window
    task automatic t_short_payload();
        int first = wr_ptr;
        load_fifo(3);
        lead(GPOS - 1, 8'h00, "R3");
        step_byte(OWN, 1'b0);
        burst_check(first, 3);
        checks++;
        if (!fifo_empty) begin
            errors++;
            $display("FAIL R7: fifo_empty=%b after window expected 1", fifo_empty);
        end
    endtask

    // R3: non-matching grant, address at other positions, K-flagged grant, no lock
    task automatic t_no_grant();
        lead(GPOS - 1, 8'h00, "R3");
        step_byte(8'h06, 1'b0);
        quiet(30, 8'h00, "R3");
        lead(GPOS - 2, OWN, "R3");
        step_byte(OWN, 1'b0);
        step_byte(8'h3F, 1'b0);
        step_byte(OWN, 1'b0);
        quiet(30, OWN, "R3");
        lead(GPOS - 1, 8'h00, "R3");
        step_byte(OWN, 1'b1);
        quiet(30, 8'h00, "R3");
        quiet(GPOS + 40, OWN, "R3");
    endtask

    // R10: comma mid-superframe restarts the count
    task automatic t_realign();
        int first = wr_ptr;
        load_fifo(5);
        lead(100, 8'h00, "R10");
        lead(GPOS - 1, 8'h00, "R10");
        step_byte(OWN, 1'b0);
        checks++;
        if (laser_en !== 1'b1) begin
            errors++;
            $display("FAIL R10: laser_en=%b after realigned grant expected 1", laser_en);
        end
        burst_check(first, 5);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        quiet(20, 8'h00, "R9");
        t_full_burst();
        t_short_payload();
        t_no_grant();
        t_realign();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule